// File: doc/BRIEF.md
# Store-Wait Load Issue Predictor

This block learns which loads have previously caused memory-ordering traps and holds such loads back at issue until the stores ahead of them have gone. It keeps a direct-mapped table of single-bit entries, indexed by a slice of the load's program counter. When trap logic elsewhere reports a trapping load, that load's entry is set. When the issue logic later presents a load PC, the entry is read combinationally. A marked load is held only while older stores remain unissued. An unmarked load passes with no delay.

Predictions go stale, so the whole table can be wiped in two ways: an explicit clear input, or a decay timer that wipes it every `decay_period_i` cycles. A period of zero switches the timer off.

The decay timer is a two-state machine:
- `TMR_OFF`: the timer is idle.
- `TMR_COUNT`: the timer counts cycles.

Its transitions are:
- *arm*: `TMR_OFF` to `TMR_COUNT`, when the period is nonzero.
- *disarm*: `TMR_COUNT` to `TMR_OFF`, when the period becomes zero.
- *tick*: `TMR_COUNT` to itself, counting up.
- *expire*: `TMR_COUNT` to itself, wiping the table and restarting the count.

Top module: `store_wait_predictor`

## Requirements
- R1: After reset every table entry is clear, so every lookup returns `lk_wait_o` = 0.
- R2: The entry index is PC bits [11:2]. Two PCs that differ only in bits [1:0] or in bits above 11 select the same entry.
- R3: A train request (`train_valid_i` = 1) sets the entry of `train_pc_i` at the next clock edge. A lookup of that entry in the same cycle still returns the old value; the new value is visible from the following cycle.
- R4: `lk_wait_o` is a combinational read of the entry selected by `lk_pc_i` in the current cycle.
- R5: `clear_i` = 1 clears every entry at the next clock edge.
- R6: When a train request and a table wipe (explicit or periodic) fall in the same cycle, all entries are cleared except the trained one, which ends up set.
- R7: `lk_hold_o` = 1 exactly when `lk_valid_i` = 1, the selected entry is set and `stores_done_i` = 0.
- R8: `lk_go_o` = 1 exactly when `lk_valid_i` = 1 and `lk_hold_o` = 0. An unmarked load goes regardless of `stores_done_i`, and a marked load goes once `stores_done_i` = 1.
- R9: Let E be the first clock edge at which `decay_period_i` = P is sampled nonzero while the timer is off. With P held constant afterwards, the table is wiped at edges E+P, E+2P, E+3P, and so on.
- R10: While `decay_period_i` = 0, no periodic wipe occurs and set entries persist.
- R11: With `lk_valid_i` = 0, both `lk_hold_o` and `lk_go_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid_i | input | 1 | A load is presented for issue |
| lk_pc_i | input | PC_W | PC of the presented load |
| stores_done_i | input | 1 | All stores older than the presented load have issued |
| train_valid_i | input | 1 | A load caused an ordering trap |
| train_pc_i | input | PC_W | PC of the trapping load |
| clear_i | input | 1 | Wipe the whole table at the next edge |
| decay_period_i | input | CNT_W | Periodic wipe interval in cycles; 0 disables |
| lk_wait_o | output | 1 | Entry bit of the presented PC |
| lk_hold_o | output | 1 | The presented load must wait |
| lk_go_o | output | 1 | The presented load may issue |

## Verification
A train request can land in the same cycle as a wipe, and that wipe can come from `clear_i` or from the decay timer expiring. A directed step trains one PC while `clear_i` is pulsed. The random phases keep training often while the timer runs with small periods, so trains regularly coincide with expiry edges. After such an edge the trained PC must read back as set and every other probed PC as clear. A cycle-by-cycle model in the bench applies the wipe first and the set second, and it judges every lookup against that model.

// File: rtl/swp_pkg.sv
package swp_pkg;

    typedef enum logic {
        TMR_OFF   = 1'b0,
        TMR_COUNT = 1'b1
    } tmr_state_e;

endpackage

// File: rtl/swp_decay_timer.sv
module swp_decay_timer
    import swp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    output logic             wipe_o
);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   cnt_inc;
    logic             period_zero;
    logic             at_limit;

    assign period_zero = (period_i == '0);
    assign cnt_inc     = {1'b0, cnt_q} + 1'b1;
    assign at_limit    = (cnt_inc >= {1'b0, period_i});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state: arm, disarm, tick, expire
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TMR_OFF: begin
                cnt_d = '0;
                if (!period_zero) state_d = TMR_COUNT;
            end
            TMR_COUNT: begin
                if (period_zero) begin
                    state_d = TMR_OFF;
                    cnt_d   = '0;
                end else if (at_limit) begin
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_inc[CNT_W-1:0];
                end
            end
            default: begin
                state_d = TMR_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        wipe_o = 1'b0;
        unique case (state_q)
            TMR_OFF:   wipe_o = 1'b0;
            TMR_COUNT: wipe_o = !period_zero && at_limit;
            default:   wipe_o = 1'b0;
        endcase
    end

    AST_WIPE_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_o |-> $past(period_i) != '0); // R9

    AST_OFF_NO_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        period_zero |-> !wipe_o); // R10

endmodule

// File: rtl/swp_bit_table.sv
module swp_bit_table #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic             rd_bit_o,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic             flush_i
);

    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] bits_q, bits_d;

    // wipe first, then set, so a same-cycle train survives
    always_comb begin
        bits_d = flush_i ? '0 : bits_q;
        if (wr_en_i) bits_d[wr_idx_i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign rd_bit_o = bits_q[rd_idx_i];

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> bits_q == '0); // R1

    AST_TRAIN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> bits_q[$past(wr_idx_i)]); // R3

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i && !wr_en_i |=> bits_q == '0); // R5

    AST_FLUSH_KEEPS_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i && wr_en_i |=> $countones(bits_q) == 1); // R6

endmodule

// File: rtl/swp_issue_gate.sv
module swp_issue_gate (
    input  logic valid_i,
    input  logic wait_bit_i,
    input  logic stores_done_i,
    output logic hold_o,
    output logic go_o
);

    always_comb begin
        hold_o = valid_i && wait_bit_i && !stores_done_i;
        go_o   = valid_i && !hold_o;
    end

endmodule

// File: rtl/store_wait_predictor.sv
module store_wait_predictor #(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 10,
    parameter int IDX_LSB = 2,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid_i,
    input  logic [PC_W-1:0]  lk_pc_i,
    input  logic             stores_done_i,
    input  logic             train_valid_i,
    input  logic [PC_W-1:0]  train_pc_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] decay_period_i,
    output logic             lk_wait_o,
    output logic             lk_hold_o,
    output logic             lk_go_o
);

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] tr_idx;
    logic             decay_wipe;
    logic             table_flush;

    assign lk_idx      = lk_pc_i[IDX_LSB +: IDX_W];
    assign tr_idx      = train_pc_i[IDX_LSB +: IDX_W];
    assign table_flush = clear_i || decay_wipe;

    swp_decay_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (decay_period_i),
        .wipe_o   (decay_wipe)
    );

    swp_bit_table #(.IDX_W(IDX_W)) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx_i (lk_idx),
        .rd_bit_o (lk_wait_o),
        .wr_en_i  (train_valid_i),
        .wr_idx_i (tr_idx),
        .flush_i  (table_flush)
    );

    swp_issue_gate i_gate (
        .valid_i       (lk_valid_i),
        .wait_bit_i    (lk_wait_o),
        .stores_done_i (stores_done_i),
        .hold_o        (lk_hold_o),
        .go_o          (lk_go_o)
    );

    AST_HOLD_ONLY_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hold_o |-> lk_wait_o && !stores_done_i && lk_valid_i); // R7

    AST_UNMARKED_GOES: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid_i && !lk_wait_o |-> lk_go_o); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid_i |-> !lk_hold_o && !lk_go_o); // R11

endmodule

// File: tb/test_store_wait_predictor.sv
module test_store_wait_predictor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid_i = 1'b0;
    logic [31:0] lk_pc_i = '0;
    logic        stores_done_i = 1'b0;
    logic        train_valid_i = 1'b0;
    logic [31:0] train_pc_i = '0;
    logic        clear_i = 1'b0;
    logic [15:0] decay_period_i = '0;
    logic        lk_wait_o, lk_hold_o, lk_go_o;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    // reference model state
    bit ref_tbl [1024];
    bit ref_on = 0;
    int ref_cnt = 0;

    always #5 clk = ~clk;

    store_wait_predictor i_store_wait_predictor (
        .clk(clk), .rst_n(rst_n), .lk_valid_i(lk_valid_i), .lk_pc_i(lk_pc_i),
        .stores_done_i(stores_done_i), .train_valid_i(train_valid_i),
        .train_pc_i(train_pc_i), .clear_i(clear_i), .decay_period_i(decay_period_i),
        .lk_wait_o(lk_wait_o), .lk_hold_o(lk_hold_o), .lk_go_o(lk_go_o)
    );

    function automatic int idx_of(logic [31:0] pc);
        return int'((pc >> 2) & 32'h3FF);   // R2: PC bits [11:2]
    endfunction

    // behavioural model, updated on each edge from the pre-edge inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (ref_tbl[i]) ref_tbl[i] = 0;
            ref_on = 0;
            ref_cnt = 0;
        end else begin
            bit wipe;
            int p;
            p = int'(decay_period_i);
            wipe = ref_on && (p != 0) && (ref_cnt + 1 >= p);
            if (clear_i || wipe) foreach (ref_tbl[i]) ref_tbl[i] = 0;
            if (train_valid_i) ref_tbl[idx_of(train_pc_i)] = 1;
            if (p == 0) begin
                ref_on = 0; ref_cnt = 0;
            end else if (!ref_on) begin
                ref_on = 1; ref_cnt = 0;
            end else if (wipe) begin
                ref_cnt = 0;
            end else begin
                ref_cnt = ref_cnt + 1;
            end
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            bit eb, eh, eg;
            eb = ref_tbl[idx_of(lk_pc_i)];
            eh = lk_valid_i && eb && !stores_done_i;
            eg = lk_valid_i && !eh;
            chk(cur_req, "lk_wait_o", lk_wait_o, eb);
            chk("R7", "lk_hold_o", lk_hold_o, eh);
            chk("R8", "lk_go_o", lk_go_o, eg);
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic probe(logic [31:0] pc, logic sd, string req, logic exp_wait);
        lk_valid_i = 1'b1; lk_pc_i = pc; stores_done_i = sd;
        @(negedge clk);
        chk(req, "probe lk_wait_o", lk_wait_o, exp_wait);
        step();
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) step();
        rst_n = 1'b1;
        step();
        probe(32'h0000_0040, 1'b0, "R1", 1'b0);
        probe(32'h0000_1FFC, 1'b0, "R1", 1'b0);

        // R3: train visible next cycle, not same cycle
        cur_req = "R3";
        train_valid_i = 1'b1; train_pc_i = 32'h0000_1004;
        lk_valid_i = 1'b1; lk_pc_i = 32'h0000_1004;
        @(negedge clk);
        chk("R3", "same-cycle lookup", lk_wait_o, 1'b0);
        step();
        train_valid_i = 1'b0;
        @(negedge clk);
        chk("R3", "next-cycle lookup", lk_wait_o, 1'b1);
        step();

        // R2: aliasing through ignored PC bits
        cur_req = "R2";
        probe(32'h0000_5007, 1'b0, "R2", 1'b1);
        probe(32'hFFFF_F005, 1'b0, "R2", 1'b1);
        probe(32'h0000_1008, 1'b0, "R2", 1'b0);

        // R7/R8/R11: gate behaviour
        cur_req = "R4";
        lk_valid_i = 1'b1; lk_pc_i = 32'h0000_1004; stores_done_i = 1'b0;
        @(negedge clk);
        chk("R7", "marked load held", lk_hold_o, 1'b1);
        chk("R7", "marked load not go", lk_go_o, 1'b0);
        step();
        stores_done_i = 1'b1;
        @(negedge clk);
        chk("R8", "marked load goes after stores", lk_go_o, 1'b1);
        step();
        lk_pc_i = 32'h0000_2000; stores_done_i = 1'b0;
        @(negedge clk);
        chk("R8", "unmarked load goes", lk_go_o, 1'b1);
        step();
        lk_valid_i = 1'b0; lk_pc_i = 32'h0000_1004;
        @(negedge clk);
        chk("R11", "idle hold", lk_hold_o, 1'b0);
        chk("R11", "idle go", lk_go_o, 1'b0);
        step();

        // R5: explicit clear
        cur_req = "R5";
        train_valid_i = 1'b1;
        for (int k = 0; k < 4; k++) begin
            train_pc_i = 32'h100 + 32'(k) * 4;
            step();
        end
        train_valid_i = 1'b0;
        clear_i = 1'b1;
        step();
        clear_i = 1'b0;
        probe(32'h0000_1004, 1'b0, "R5", 1'b0);
        probe(32'h0000_0108, 1'b0, "R5", 1'b0);

        // R6: train and clear in the same cycle
        cur_req = "R6";
        train_valid_i = 1'b1; train_pc_i = 32'h0000_0200;
        step();
        train_pc_i = 32'h0000_0300; clear_i = 1'b1;
        step();
        train_valid_i = 1'b0; clear_i = 1'b0;
        probe(32'h0000_0300, 1'b0, "R6", 1'b1);
        probe(32'h0000_0200, 1'b0, "R6", 1'b0);

        // R4: random traffic, explicit clear only
        cur_req = "R4";
        for (int n = 0; n < 400; n++) begin
            lk_valid_i    = 1'($urandom_range(0, 1));
            lk_pc_i       = $urandom & 32'h0000_F0FF;
            stores_done_i = 1'($urandom_range(0, 1));
            train_valid_i = ($urandom_range(0, 3) == 0);
            train_pc_i    = $urandom & 32'h0000_F0FF;
            clear_i       = ($urandom_range(0, 60) == 0);
            step();
        end
        train_valid_i = 1'b0; clear_i = 1'b0;

        // R9: directed decay timing with period 7
        cur_req = "R9";
        clear_i = 1'b1;
        step();
        clear_i = 1'b0;
        decay_period_i = 16'd7;
        train_valid_i = 1'b1; train_pc_i = 32'h0000_0444;
        step();                       // arming edge E
        train_valid_i = 1'b0;
        repeat (6) step();            // now just past E+6
        probe(32'h0000_0444, 1'b0, "R9", 1'b1);   // probe spans edge E+7: wipe
        lk_pc_i = 32'h0000_0444;
        @(negedge clk);
        chk("R9", "entry wiped at E+P", lk_wait_o, 1'b0);
        step();

        // R9/R6: random traffic under the decay timer
        for (int n = 0; n < 300; n++) begin
            lk_valid_i    = 1'b1;
            lk_pc_i       = $urandom & 32'h0000_00FC;
            stores_done_i = 1'($urandom_range(0, 1));
            train_valid_i = ($urandom_range(0, 1) == 0);
            train_pc_i    = $urandom & 32'h0000_00FC;
            step();
        end
        decay_period_i = 16'd1;
        for (int n = 0; n < 40; n++) begin
            lk_pc_i       = $urandom & 32'h0000_00FC;
            train_valid_i = 1'($urandom_range(0, 1));
            train_pc_i    = $urandom & 32'h0000_00FC;
            step();
        end
        decay_period_i = 16'd3;
        for (int n = 0; n < 60; n++) begin
            lk_pc_i       = $urandom & 32'h0000_00FC;
            train_valid_i = 1'($urandom_range(0, 1));
            train_pc_i    = $urandom & 32'h0000_00FC;
            step();
        end

        // R10: timer disabled, entries persist
        cur_req = "R10";
        decay_period_i = 16'd0;
        train_valid_i = 1'b1; train_pc_i = 32'h0000_0888;
        step();
        train_valid_i = 1'b0;
        repeat (80) step();
        probe(32'h0000_0888, 1'b0, "R10", 1'b1);

        finish_run();
    end

endmodule